// File: doc/BRIEF.md
# Skewed Eight-Channel Serial-to-Parallel Converter

The converter accepts eight serial streams that share one bit clock. It collects a 32-bit word from each stream and presents the words, one per read, on a second clock that is independent of the first. The conversion does not use one shift register per channel. Each channel instead passes through a delay line whose length equals its channel index. At any accepted bit time the eight delayed bits therefore all have different bit indices modulo eight.

A bank of eight 8:1 selectors routes these bits into eight one-bit-wide storage slices. Slice j holds every bit whose index is j modulo eight, for all channels and both buffer halves, so all eight slices are written on every accepted bit. Storage is double-buffered: the writer fills one half bit by bit while the reader drains the other half as whole words. Frame completion is passed to the read clock through a toggle synchronizer, and the drain of a half is passed back to the write clock the same way.

The writer may begin a new frame only in a half that has been fully drained. Otherwise it holds at the frame boundary and ignores the serial input. A frame only becomes readable after the writer has accepted seven bits of the next frame, because those bits carry the delayed tail of the skewed channels.

Top module: `skew_s2p_conv`

## Requirements
- R1: While reset is asserted and after it is released, with no data written, rd_avail and rd_valid are 0 and rd_data is all zeros.
- R2: For each channel k, the word read back for that channel has bit i equal to the i-th serial bit accepted on ser_in[k] within the frame. Bits arrive least significant bit first, and a frame is 32 accepted bits.
- R3: A frame becomes readable (rd_avail goes to 1) only after seven further bits of the following frame have been accepted. After only six such bits, rd_avail stays 0.
- R4: A write-clock cycle with wr_en low is not an accepted bit. It changes no stored data and does not advance the frame position, whatever ser_in carries.
- R5: Every accepted read (rd_en high while rd_avail is high) is answered on the next read-clock cycle with rd_valid high, rd_data holding the word and rd_chan holding its channel. Within a frame the channels come out in the order 0 to 7, with consecutive read cycles allowed.
- R6: rd_en while rd_avail is low is ignored. rd_valid stays 0, rd_data keeps its value, and the next accepted read still returns the expected channel.
- R7: Successive frames are stored in alternating halves and are read back in the order they were written.
- R8: At a frame boundary, when the half to be filled next still holds an unread frame, accepted-looking bits (wr_en high) are ignored until that half has been drained. The unread frame and the still-incomplete frame both stay intact.
- R9: After the eighth read of a frame, rd_avail drops to 0 in the next cycle if the other half does not yet hold a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Serial bit clock |
| rd_clk | input | 1 | Word read clock, independent of wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Serial bit strobe; ser_in is taken when high |
| ser_in | input | 8 | One serial bit per channel |
| rd_en | input | 1 | Read request for the next word |
| rd_avail | output | 1 | A complete frame is ready to read |
| rd_valid | output | 1 | rd_data and rd_chan carry a word this cycle |
| rd_chan | output | 3 | Channel index of the word on rd_data |
| rd_data | output | 32 | Parallel word |

## Verification
The bench targets the skew tail. It checks that a frame stays hidden after six bits of the next frame and appears after the seventh. A design that flagged completion at the thirty-second bit would hand out words whose upper bits for the late channels are stale. Per-channel patterns that differ in every bit position expose a selector or slice-address error, which shows up as bits swapped between channels or between byte groups. Idle write cycles with noise on the inputs are interleaved into a frame, catching delay lines that shift without the strobe. The writer is also driven into a full half at a frame boundary. This shows whether it discards the extra bits or, in a faulty design, overwrites an unread frame or corrupts the pending tail. The bench also issues reads while nothing is ready and then reads back to back, which would reveal a read pointer that advances on rejected requests.

// File: rtl/s2p_skew_pkg.sv
package s2p_skew_pkg;
  localparam int DEF_CH_N   = 8;
  localparam int DEF_WORD_W = 32;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/s2p_sync2.sv
module s2p_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/s2p_skew_line.sv
module s2p_skew_line #(
  parameter int CH_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [CH_N-1:0] din,
  output logic [CH_N-1:0] dout
);
  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    if (k == 0) begin : g_direct
      assign dout[0] = din[0];
    end else begin : g_delay
      logic [k:0] tap;
      assign tap[0] = din[k];
      for (genvar s = 1; s <= k; s++) begin : g_stage
        logic stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   stage_q <= 1'b0;
          else if (adv) stage_q <= tap[s-1];
        end
        assign tap[s] = stage_q;
      end
      assign dout[k] = tap[k];
    end
  end
endmodule

// File: rtl/s2p_write_router.sv
module s2p_write_router #(
  parameter int CH_N   = 8,
  parameter int WORD_W = 32,
  localparam int CH_W   = $clog2(CH_N),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int GRP_W  = $clog2(WORD_W / CH_N),
  localparam int ADDR_W = 1 + CH_W + GRP_W
) (
  input  logic [BIT_W-1:0]             wcnt,
  input  logic                         whalf,
  input  logic [CH_N-1:0]              skew_bits,
  output logic [CH_N-1:0]              sl_bit,
  output logic [CH_N-1:0][ADDR_W-1:0]  sl_addr
);
  for (genvar j = 0; j < CH_N; j++) begin : g_slice
    logic [CH_W-1:0]  src_ch;
    logic [BIT_W-1:0] bit_idx;
    logic             in_prev;

    always_comb begin
      src_ch  = wcnt[CH_W-1:0] - CH_W'(j);
      bit_idx = wcnt - BIT_W'(src_ch);
      in_prev = (wcnt < BIT_W'(src_ch));
      sl_bit[j]  = skew_bits[src_ch];
      sl_addr[j] = {whalf ^ in_prev, src_ch, bit_idx[BIT_W-1:CH_W]};
    end
  end
endmodule

// File: rtl/s2p_slice_store.sv
module s2p_slice_store #(
  parameter int CH_N   = 8,
  parameter int WORD_W = 32,
  localparam int CH_W   = $clog2(CH_N),
  localparam int GRP_W  = $clog2(WORD_W / CH_N),
  localparam int ADDR_W = 1 + CH_W + GRP_W,
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic                        wr_clk,
  input  logic                        we,
  input  logic [CH_N-1:0]             wbit,
  input  logic [CH_N-1:0][ADDR_W-1:0] waddr,
  input  logic                        rd_half,
  input  logic [CH_W-1:0]             rd_ch,
  output logic [WORD_W-1:0]           rword
);
  logic [DEPTH-1:0] slice_q [CH_N];

  always_ff @(posedge wr_clk) begin
    for (int j = 0; j < CH_N; j++) begin
      if (we) slice_q[j][waddr[j]] <= wbit[j];
    end
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_rd
    localparam int SL = b % CH_N;
    localparam int GR = b / CH_N;
    assign rword[b] = slice_q[SL][{rd_half, rd_ch, GRP_W'(GR)}];
  end
endmodule

// File: rtl/skew_s2p_conv.sv
module skew_s2p_conv
  import s2p_skew_pkg::*;
#(
  parameter int CH_N   = DEF_CH_N,
  parameter int WORD_W = DEF_WORD_W,
  localparam int CH_W   = $clog2(CH_N),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int GRP_W  = $clog2(WORD_W / CH_N),
  localparam int ADDR_W = 1 + CH_W + GRP_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_N-1:0]   ser_in,
  input  logic              rd_en,
  output logic              rd_avail,
  output logic              rd_valid,
  output logic [CH_W-1:0]   rd_chan,
  output logic [WORD_W-1:0] rd_data
);
  // reset release per domain
  logic [SYNC_DEPTH-1:0] wr_rst_pipe, rd_rst_pipe;
  logic wr_rst_n, rd_rst_n;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wr_rst_pipe <= '0;
    else        wr_rst_pipe <= {wr_rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rd_rst_pipe <= '0;
    else        rd_rst_pipe <= {rd_rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign wr_rst_n = wr_rst_pipe[SYNC_DEPTH-1];
  assign rd_rst_n = rd_rst_pipe[SYNC_DEPTH-1];

  // write side state
  logic [BIT_W-1:0] wcnt_q, wcnt_n;
  logic             whalf_q, whalf_n;
  logic             primed_q, primed_n;
  logic [1:0]       wfill_tog_q, wfill_tog_n;
  logic [1:0]       rdrain_wr;
  logic             half_free, stall, wr_adv;

  // read side state
  logic [1:0]        rdrain_tog_q, rdrain_tog_n;
  logic [1:0]        wfill_rd;
  logic [1:0]        half_full;
  logic              rhalf_q, rhalf_n;
  logic [CH_W-1:0]   rch_q, rch_n;
  logic              rd_take;
  logic              rvalid_q;
  logic [CH_W-1:0]   rchan_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rword;

  logic [CH_N-1:0]             skew_bits;
  logic [CH_N-1:0]             sl_bit;
  logic [CH_N-1:0][ADDR_W-1:0] sl_addr;

  // write control
  always_comb begin
    half_free   = (wfill_tog_q[whalf_q] == rdrain_wr[whalf_q]);
    stall       = (wcnt_q == '0) && !half_free;
    wr_adv      = wr_en && !stall;
    wcnt_n      = wcnt_q;
    whalf_n     = whalf_q;
    primed_n    = primed_q;
    wfill_tog_n = wfill_tog_q;
    if (wr_adv) begin
      wcnt_n = wcnt_q + 1'b1;
      if (wcnt_q == BIT_W'(WORD_W - 1)) begin
        whalf_n  = ~whalf_q;
        primed_n = 1'b1;
      end
      if (primed_q && (wcnt_q == BIT_W'(CH_N - 2)))
        wfill_tog_n[~whalf_q] = ~wfill_tog_q[~whalf_q];
    end
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wcnt_q      <= '0;
      whalf_q     <= 1'b0;
      primed_q    <= 1'b0;
      wfill_tog_q <= '0;
    end else begin
      wcnt_q      <= wcnt_n;
      whalf_q     <= whalf_n;
      primed_q    <= primed_n;
      wfill_tog_q <= wfill_tog_n;
    end
  end

  s2p_skew_line #(.CH_N(CH_N)) u_skew (
    .clk(wr_clk), .rst_n(wr_rst_n), .adv(wr_adv), .din(ser_in), .dout(skew_bits)
  );

  s2p_write_router #(.CH_N(CH_N), .WORD_W(WORD_W)) u_route (
    .wcnt(wcnt_q), .whalf(whalf_q), .skew_bits(skew_bits),
    .sl_bit(sl_bit), .sl_addr(sl_addr)
  );

  s2p_slice_store #(.CH_N(CH_N), .WORD_W(WORD_W)) u_store (
    .wr_clk(wr_clk), .we(wr_adv), .wbit(sl_bit), .waddr(sl_addr),
    .rd_half(rhalf_q), .rd_ch(rch_q), .rword(rword)
  );

  s2p_sync2 #(.W(2)) u_fill_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wfill_tog_q), .q(wfill_rd)
  );
  s2p_sync2 #(.W(2)) u_drain_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rdrain_tog_q), .q(rdrain_wr)
  );

  // read control
  always_comb begin
    half_full    = wfill_rd ^ rdrain_tog_q;
    rd_avail     = half_full[rhalf_q];
    rd_take      = rd_en && rd_avail;
    rch_n        = rch_q;
    rhalf_n      = rhalf_q;
    rdrain_tog_n = rdrain_tog_q;
    if (rd_take) begin
      rch_n = rch_q + 1'b1;
      if (rch_q == CH_W'(CH_N - 1)) begin
        rhalf_n               = ~rhalf_q;
        rdrain_tog_n[rhalf_q] = ~rdrain_tog_q[rhalf_q];
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rch_q        <= '0;
      rhalf_q      <= 1'b0;
      rdrain_tog_q <= '0;
      rvalid_q     <= 1'b0;
    end else begin
      rch_q        <= rch_n;
      rhalf_q      <= rhalf_n;
      rdrain_tog_q <= rdrain_tog_n;
      rvalid_q     <= rd_take;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rdata_q <= '0;
      rchan_q <= '0;
    end else if (rd_take) begin
      rdata_q <= rword;
      rchan_q <= rch_q;
    end
  end

  assign rd_valid = rvalid_q;
  assign rd_chan  = rchan_q;
  assign rd_data  = rdata_q;
endmodule

// File: rtl/s2p_skew_chk.sv
module s2p_skew_chk #(
  parameter int CH_W   = 3,
  parameter int BIT_W  = 5,
  parameter int WORD_W = 32
) (
  input logic              rd_clk,
  input logic              wr_clk,
  input logic              rd_rst_n,
  input logic              wr_rst_n,
  input logic              rd_en,
  input logic              rd_avail,
  input logic              rd_valid,
  input logic [CH_W-1:0]   rd_chan,
  input logic [WORD_W-1:0] rd_data,
  input logic              wr_en,
  input logic [BIT_W-1:0]  wcnt
);
  logic [CH_W-1:0] exp_ch_q;
  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)     exp_ch_q <= '0;
    else if (rd_valid) exp_ch_q <= exp_ch_q + 1'b1;
  end

  // R5
  valid_origin_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> $past(rd_en && rd_avail));

  // R6
  idle_read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && rd_avail) |=> (!rd_valid && $stable(rd_data)));

  // R5
  chan_order_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> (rd_chan == exp_ch_q));

  // R4
  gap_no_advance_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_en |=> $stable(wcnt));
endmodule

bind skew_s2p_conv s2p_skew_chk #(.CH_W(CH_W), .BIT_W(BIT_W), .WORD_W(WORD_W)) u_chk (
  .rd_clk(rd_clk), .wr_clk(wr_clk), .rd_rst_n(rd_rst_n), .wr_rst_n(wr_rst_n),
  .rd_en(rd_en), .rd_avail(rd_avail), .rd_valid(rd_valid), .rd_chan(rd_chan),
  .rd_data(rd_data), .wr_en(wr_en), .wcnt(wcnt_q)
);

// File: tb/tb_skew_s2p_conv.sv
module tb_skew_s2p_conv;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  ser_in;
  logic        rd_en;
  logic        rd_avail;
  logic        rd_valid;
  logic [2:0]  rd_chan;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  skew_s2p_conv dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .ser_in(ser_in), .rd_en(rd_en), .rd_avail(rd_avail), .rd_valid(rd_valid),
    .rd_chan(rd_chan), .rd_data(rd_data)
  );

  function automatic logic [31:0] fw(int f, int c);
    logic [31:0] x;
    if (f == 1) return (c % 2 == 0) ? 32'hFFFF_FFFF : (32'h8000_0001 << c);
    x = 32'h9E37_79B9 * (f * 8 + c + 1);
    return x ^ {x[15:0], x[31:16]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input int f, input int lo, input int hi, input bit gaps);
    for (int i = lo; i <= hi; i++) begin
      if (gaps && (i % 3 == 0)) begin
        @(negedge wr_clk);
        wr_en  = 1'b0;
        ser_in = 8'h5A ^ 8'(i);
      end
      @(negedge wr_clk);
      wr_en = 1'b1;
      for (int c = 0; c < 8; c++) ser_in[c] = fw(f, c)[i];
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic wait_avail(input string tag);
    int t;
    t = 0;
    while (!rd_avail && t < 200) begin
      @(negedge rd_clk);
      t++;
    end
    chk(rd_avail === 1'b1, tag, 32'(rd_avail), 32'd1);
  endtask

  task automatic read_frame_pulsed(input int f, input string tag);
    for (int c = 0; c < 8; c++) begin
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      chk(rd_valid === 1'b1, {tag, " R5 valid"}, 32'(rd_valid), 32'd1);
      chk(rd_chan === 3'(c), {tag, " R5 chan"}, 32'(rd_chan), 32'(c));
      chk(rd_data === fw(f, c), {tag, " R2 data"}, rd_data, fw(f, c));
    end
  endtask

  task automatic read_frame_stream(input int f, input string tag);
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge rd_clk);
      if (c == 7) rd_en = 1'b0;
      chk(rd_valid === 1'b1, {tag, " R5 stream valid"}, 32'(rd_valid), 32'd1);
      chk(rd_chan === 3'(c), {tag, " R5 stream chan"}, 32'(rd_chan), 32'(c));
      chk(rd_data === fw(f, c), {tag, " R2 stream data"}, rd_data, fw(f, c));
    end
    @(negedge rd_clk);
    chk(rd_valid === 1'b0, {tag, " R5 stream end"}, 32'(rd_valid), 32'd0);
  endtask

  // R1
  task automatic t_reset();
    chk(rd_avail === 1'b0, "R1 avail", 32'(rd_avail), 32'd0);
    chk(rd_valid === 1'b0, "R1 valid", 32'(rd_valid), 32'd0);
    chk(rd_data === 32'h0, "R1 data", rd_data, 32'h0);
  endtask

  // R3, R2, R5, R9
  task automatic t_first_frame();
    send_bits(0, 0, 31, 1'b0);
    send_bits(1, 0, 5, 1'b0);
    wait_wr(12);
    chk(rd_avail === 1'b0, "R3 hidden after six tail bits", 32'(rd_avail), 32'd0);
    send_bits(1, 6, 6, 1'b0);
    wait_avail("R3 visible after seventh tail bit");
    read_frame_pulsed(0, "frameA");
    chk(rd_avail === 1'b0, "R9 avail drops after drain", 32'(rd_avail), 32'd0);
  endtask

  // R6
  task automatic t_idle_read();
    logic [31:0] held;
    held = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R6 no valid on rejected read", 32'(rd_valid), 32'd0);
    chk(rd_data === held, "R6 data held", rd_data, held);
  endtask

  // R4, R5, R7
  task automatic t_gaps_stream();
    send_bits(1, 7, 31, 1'b1);
    send_bits(2, 0, 6, 1'b1);
    wait_avail("R7 frameB ready");
    read_frame_stream(1, "R4 gapped frameB");
  endtask

  // R8, R7
  task automatic t_full_stall();
    send_bits(2, 7, 31, 1'b0);
    send_bits(3, 0, 31, 1'b0);
    send_bits(5, 0, 2, 1'b0);
    wait_avail("R7 frameC ready");
    read_frame_pulsed(2, "R7 frameC");
    wait_wr(12);
    chk(rd_avail === 1'b0, "R8 frameD not complete yet", 32'(rd_avail), 32'd0);
    send_bits(4, 0, 6, 1'b0);
    wait_avail("R8 frameD ready");
    read_frame_pulsed(3, "R8 frameD intact");
    send_bits(4, 7, 31, 1'b0);
    send_bits(5, 0, 6, 1'b0);
    wait_avail("R8 frameE ready");
    read_frame_pulsed(4, "R8 frameE without dropped bits");
  endtask

  initial begin
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    ser_in = 8'h00;
    rd_en  = 1'b0;
    wait_wr(4);
    t_reset();
    @(negedge wr_clk);
    rst_n = 1'b1;
    wait_wr(6);
    t_reset();
    t_first_frame();
    t_idle_read();
    t_gaps_stream();
    t_full_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule